// File: doc/BRIEF.md
# Receive Word Queue with Watermark Request

This block sits between a serial receive engine and the bus-facing register logic. Each time the engine completes a word, the block stores that word in an eight-entry first-in first-out buffer. It stores the two error flags found for that word (noise and parity) in the same entry, so a consumer always reads a word together with its own status. The oldest stored entry is always visible on the read outputs. A one-cycle pop strobe discards that entry and brings the next one forward.

The block compares the number of stored words with a programmable threshold. When the count reaches the threshold, the block raises a ready indication. A mode input sends that indication either to a DMA request or, if the receive interrupt is enabled, to an interrupt request. If the engine delivers a word while the buffer is full, the block drops the word and sets a sticky overrun flag. That flag stays set until the clear input is pulsed.

Top module: `rxq_watermark_fifo`

## Requirements
- R1: After a synchronous reset, `level` is 0 and `data_ready`, `irq_req`, `dma_req` and `overrun` are all 0.
- R2: Entries leave in the order they were written. While `level` is nonzero, `rd_data`, `rd_noise` and `rd_parity` show the oldest entry's word and its own two flags, with no pop needed. A pop advances to the next entry at the following clock edge.
- R3: `data_ready` is 1 exactly when `level` is at least the threshold. The threshold is `watermark`, except that a watermark of 0 is used as 1. `data_ready` changes at the same clock edge as the `level` it reflects.
- R4: `irq_req` equals `data_ready` when `irq_en` is 1 and `dma_mode` is 0; otherwise it is 0.
- R5: When `dma_mode` is 1, `dma_req` equals `data_ready` whatever `irq_en` is, and `irq_req` is 0. When `dma_mode` is 0, `dma_req` is 0.
- R6: A write with `level` equal to 8 and no pop in the same cycle is discarded. `level` and the stored entries are left unchanged, and `overrun` becomes 1 at that edge.
- R7: `overrun` stays 1 until a cycle with `overrun_clr` high. If a discarded write and `overrun_clr` occur in the same cycle, `overrun` remains 1.
- R8: A pop while `level` is 0 has no effect. `level` stays 0 and no request is raised.
- R9: A write and a pop in the same cycle are both honoured when the buffer is full. In that case `level` stays 8 and the new word joins the tail. When the buffer is empty, the write is stored and `level` becomes 1.
- R10: `level` never exceeds 8 and reaches 8 after eight writes into an empty buffer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Receive engine delivers a word this cycle |
| wr_data | input | DATA_W | Received word |
| wr_noise | input | 1 | Noise detected on this word |
| wr_parity | input | 1 | Parity error on this word |
| rd_pop | input | 1 | Consume the oldest entry |
| rd_data | output | DATA_W | Oldest stored word |
| rd_noise | output | 1 | Noise flag of the oldest entry |
| rd_parity | output | 1 | Parity flag of the oldest entry |
| watermark | input | CNT_W | Ready threshold (0 treated as 1) |
| irq_en | input | 1 | Receive interrupt enable |
| dma_mode | input | 1 | Route ready to the DMA request instead of the interrupt |
| overrun_clr | input | 1 | Clear the sticky overrun flag |
| level | output | CNT_W | Number of stored entries, 0 to 8 |
| data_ready | output | 1 | Stored count at or above threshold |
| irq_req | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |
| overrun | output | 1 | Sticky flag: a word was dropped while full |

## Verification
A write and a pop can fall in the same cycle. The delicate cases are when the buffer is full, where the pop frees the slot that the write needs, and when it is empty, where the pop must be ignored while the write lands. The bench drives both strobes together at each boundary and compares the level, the head entry and the later drain order against a queue model. A dropped write and an overrun clear can also coincide. The bench provokes that collision and expects the flag to stay set.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef struct packed {
    logic noise;
    logic parity;
  } rxq_flags_t;

  localparam int FLAG_W = $bits(rxq_flags_t);
endpackage

// File: rtl/rxq_storage.sv
module rxq_storage #(
  parameter int WIDTH = 10,
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rxq_ptr_ctrl.sv
module rxq_ptr_ctrl #(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_req,
  input  logic          pop_req,
  input  logic          ovr_clr,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic [CW-1:0] level,
  output logic [CW-1:0] level_next,
  output logic          overrun
);
  logic [AW-1:0] wptr, rptr;
  logic          pop_ok, wr_ok, drop;
  logic          full, empty;

  assign full   = (level == CW'(DEPTH));
  assign empty  = (level == '0);
  assign pop_ok = pop_req && !empty;
  assign wr_ok  = wr_req && (!full || pop_ok);
  assign drop   = wr_req && !wr_ok;

  assign we    = wr_ok;
  assign waddr = wptr;
  assign raddr = rptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    level_next = level;
    case ({wr_ok, pop_ok})
      2'b10:   level_next = level + CW'(1);
      2'b01:   level_next = level - CW'(1);
      default: level_next = level;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr    <= '0;
      rptr    <= '0;
      level   <= '0;
      overrun <= 1'b0;
    end else begin
      if (wr_ok)  wptr <= bump(wptr);
      if (pop_ok) rptr <= bump(rptr);
      level <= level_next;
      if (drop)         overrun <= 1'b1;
      else if (ovr_clr) overrun <= 1'b0;
    end
  end

  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (rst)
    level <= CW'(DEPTH)); // R10
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (full && wr_req && !pop_req) |=> (level == $past(level)) && overrun); // R6
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (overrun && !ovr_clr) |=> overrun); // R7
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
    (empty && pop_req && !wr_req) |=> (level == '0)); // R8
  AST_BOTH_FULL: assert property (@(posedge clk) disable iff (rst)
    (full && wr_req && pop_req) |=> (level == CW'(DEPTH))); // R9
endmodule

// File: rtl/rxq_req_steer.sv
module rxq_req_steer #(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] level_next,
  input  logic [CW-1:0] watermark,
  input  logic          irq_en,
  input  logic          dma_mode,
  output logic          data_ready,
  output logic          irq_req,
  output logic          dma_req
);
  logic [CW-1:0] thresh;
  logic          rdy_next;

  assign thresh   = (watermark == '0) ? CW'(1) : watermark;
  assign rdy_next = (level_next >= thresh);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_ready <= 1'b0;
      irq_req    <= 1'b0;
      dma_req    <= 1'b0;
    end else begin
      data_ready <= rdy_next;
      irq_req    <= rdy_next && irq_en && !dma_mode;
      dma_req    <= rdy_next && dma_mode;
    end
  end

  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(irq_req && dma_req)); // R4
  AST_REQ_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
    (irq_req || dma_req) |-> data_ready); // R5
endmodule

// File: rtl/rxq_watermark_fifo.sv
module rxq_watermark_fifo
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int ENT_W = DATA_W + FLAG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_noise,
  input  logic              wr_parity,
  input  logic              rd_pop,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_noise,
  output logic              rd_parity,
  input  logic [CNT_W-1:0]  watermark,
  input  logic              irq_en,
  input  logic              dma_mode,
  input  logic              overrun_clr,
  output logic [CNT_W-1:0]  level,
  output logic              data_ready,
  output logic              irq_req,
  output logic              dma_req,
  output logic              overrun
);
  rxq_flags_t        wflags, rflags;
  logic [ENT_W-1:0]  wentry, rentry;
  logic              we;
  logic [AW-1:0]     waddr, raddr;
  logic [CNT_W-1:0]  level_next;

  assign wflags.noise  = wr_noise;
  assign wflags.parity = wr_parity;
  assign wentry        = {wflags, wr_data};
  assign rflags        = rxq_flags_t'(rentry[ENT_W-1 -: FLAG_W]);
  assign rd_data       = rentry[DATA_W-1:0];
  assign rd_noise      = rflags.noise;
  assign rd_parity     = rflags.parity;

  rxq_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .wr_req     (wr_valid),
    .pop_req    (rd_pop),
    .ovr_clr    (overrun_clr),
    .we         (we),
    .waddr      (waddr),
    .raddr      (raddr),
    .level      (level),
    .level_next (level_next),
    .overrun    (overrun)
  );

  rxq_storage #(.WIDTH(ENT_W), .DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .we    (we),
    .waddr (waddr),
    .wdata (wentry),
    .raddr (raddr),
    .rdata (rentry)
  );

  rxq_req_steer #(.DEPTH(DEPTH)) u_steer (
    .clk        (clk),
    .rst        (rst),
    .level_next (level_next),
    .watermark  (watermark),
    .irq_en     (irq_en),
    .dma_mode   (dma_mode),
    .data_ready (data_ready),
    .irq_req    (irq_req),
    .dma_req    (dma_req)
  );

  AST_EMPTY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    (level == '0) |-> !data_ready); // R3
endmodule

// File: tb/sim_rxq_watermark_fifo.sv
module sim_rxq_watermark_fifo;
  localparam int DW = 8;
  localparam int DEPTH = 8;
  localparam int CW = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_valid = 0, wr_noise = 0, wr_parity = 0, rd_pop = 0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          rd_noise, rd_parity;
  logic [CW-1:0] watermark = '0;
  logic          irq_en = 0, dma_mode = 0, overrun_clr = 0;
  logic [CW-1:0] level;
  logic          data_ready, irq_req, dma_req, overrun;

  int checks = 0, failures = 0;
  bit done = 0;
  int gen = 0;
  logic [DW+1:0] q[$];
  bit exp_ovr = 0;

  always #5 clk = ~clk;

  rxq_watermark_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_noise(wr_noise), .wr_parity(wr_parity), .rd_pop(rd_pop),
    .rd_data(rd_data), .rd_noise(rd_noise), .rd_parity(rd_parity),
    .watermark(watermark), .irq_en(irq_en), .dma_mode(dma_mode),
    .overrun_clr(overrun_clr), .level(level), .data_ready(data_ready),
    .irq_req(irq_req), .dma_req(dma_req), .overrun(overrun)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_state(string tag);
    int th = (watermark == 0) ? 1 : int'(watermark);
    bit rdy = (q.size() >= th);
    chk(tag, "level", int'(level), q.size());
    chk(tag, "data_ready", int'(data_ready), int'(rdy));
    chk(tag, "irq_req", int'(irq_req), int'(rdy && irq_en && !dma_mode));
    chk(tag, "dma_req", int'(dma_req), int'(rdy && dma_mode));
    chk(tag, "overrun", int'(overrun), int'(exp_ovr));
    if (q.size() > 0) begin
      chk(tag, "head", int'({rd_noise, rd_parity, rd_data}), int'(q[0]));
    end
  endtask

  // one clock: inputs driven at negedge, checked 1 ns after the rising edge
  task automatic cyc(bit wr, bit pop, bit clr, string tag);
    logic [DW+1:0] ent;
    bit pop_ok, wr_ok;
    @(negedge clk);
    ent = {gen[0], gen[1], DW'(gen * 29 + 11)};
    wr_valid = wr; rd_pop = pop; overrun_clr = clr;
    {wr_noise, wr_parity, wr_data} = ent;
    if (wr) gen++;
    @(posedge clk);
    pop_ok = pop && (q.size() > 0);
    wr_ok  = wr && (q.size() < DEPTH || pop_ok);
    if (pop_ok) void'(q.pop_front());
    if (wr_ok) q.push_back(ent);
    if (wr && !wr_ok) exp_ovr = 1;
    else if (clr) exp_ovr = 0;
    #1;
    wr_valid = 0; rd_pop = 0; overrun_clr = 0;
    check_state(tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    check_state("R1");

    cyc(0, 1, 0, "R8");
    cyc(0, 1, 0, "R8");

    // sweep every threshold, every fill level, every routing configuration
    for (int wm = 0; wm <= DEPTH + 1; wm++) begin
      @(negedge clk); watermark = CW'(wm);
      cyc(0, 0, 0, "R3");
      for (int lv = 0; lv <= DEPTH; lv++) begin
        for (int cfg = 0; cfg < 4; cfg++) begin
          @(negedge clk); irq_en = cfg[0]; dma_mode = cfg[1];
          cyc(0, 0, 0, cfg[1] ? "R5" : "R4");
        end
        if (lv < DEPTH) cyc(1, 0, 0, (lv == DEPTH - 1) ? "R10" : "R3");
      end
      for (int k = 0; k < DEPTH; k++) cyc(0, 1, 0, "R2");
    end

    // overrun and its clear
    @(negedge clk); watermark = CW'(4); irq_en = 1; dma_mode = 0;
    for (int k = 0; k < DEPTH; k++) cyc(1, 0, 0, "R10");
    cyc(1, 0, 0, "R6");
    cyc(1, 0, 0, "R6");
    cyc(0, 0, 0, "R7");
    cyc(0, 0, 1, "R7");
    cyc(1, 0, 0, "R6");
    cyc(1, 0, 1, "R7");
    cyc(0, 0, 1, "R7");

    // simultaneous write and pop while full
    for (int k = 0; k < 5; k++) cyc(1, 1, 0, "R9");
    for (int k = 0; k < DEPTH; k++) cyc(0, 1, 0, "R2");
    cyc(0, 1, 0, "R8");

    // simultaneous write and pop while empty
    cyc(1, 1, 0, "R9");
    cyc(1, 1, 0, "R9");
    cyc(0, 1, 0, "R2");
    cyc(0, 0, 0, "R8");

    // mid-level interleave
    for (int k = 0; k < 3; k++) cyc(1, 0, 0, "R2");
    for (int k = 0; k < 6; k++) cyc(1, 1, 0, "R2");
    for (int k = 0; k < 3; k++) cyc(0, 1, 0, "R2");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end
endmodule